// File: doc/BRIEF.md
# Write-Update Coherence Controller with Adaptive Invalidation

This block is the coherence engine for one private, direct-mapped, write-back cache in a multi-cache system that keeps copies coherent by update rather than by invalidation. Every line is Invalid, Exclusive, SharedClean, SharedModified or Modified. A processor write to a shared line puts the new word on the bus as an update, so peer copies stay valid. A line that was written while shared stays dirty in the writer (SharedModified) and becomes SharedClean in each receiver. A write to a shared line that no peer still holds goes straight to Modified with no bus traffic.

A competitive mode, selected at run time, gives each line a 2-bit saturating use counter. Local accesses raise it, and snooped updates lower it. A snooped update that finds the counter already at zero drops the line instead of taking the data. A line that peers keep writing but the local processor no longer reads therefore leaves the cache, and the update traffic to it stops. Memory, the other caches and bus arbitration are outside the block. The bus is modelled as one atomic transfer per grant.

Top module: `wu_coh_ctrl`

## Requirements
- R1: Address bits [IDX_W-1:0] select the line and the upper bits form the tag. A read hit returns the stored word on `cpu_rdata` with `cpu_done` and makes no bus request. A read miss issues one fill (`bus_cmd`=1) at the request address and installs `bus_rdata`. The line becomes Exclusive if `bus_shared_in` is low at the grant and SharedClean if it is high.
- R2: A write to a SharedClean or SharedModified line while `bus_shared_in` is high issues one update (`bus_cmd`=2) carrying the request address and the new word. The writer's line becomes SharedModified.
- R3: A write to a SharedClean or SharedModified line while `bus_shared_in` is low completes with no bus request and leaves the line Modified.
- R4: A write to an Exclusive or Modified line completes with no bus request and leaves the line Modified.
- R5: A miss that displaces a SharedModified or Modified line first issues a writeback (`bus_cmd`=3) with the victim's address and word, and then issues the fill. A displaced Exclusive or SharedClean line is dropped silently. A write miss performs the fill and then follows R2 to R4.
- R6: Snoop inputs never start a bus transaction. A snooped read demotes Exclusive to SharedClean and Modified to SharedModified. `snp_supply` is high, and `snp_sdata` carries the word, while a snooped read hits a SharedModified or Modified line.
- R7: `snp_shared` is high in the same cycle exactly when the line selected by `snp_addr` is valid and its tag matches.
- R8: A snooped update that hits, and does not invalidate under R10, replaces the word and leaves the line SharedClean.
- R9: With `compete_en` high, a fill loads the counter with 3. Each completed processor access to the line adds 1, saturating at 3. Each snooped update that hits subtracts 1, saturating at 0. With `compete_en` low the counter does not change.
- R10: With `compete_en` high, a snooped update that hits a line whose counter is 0 invalidates the line instead of updating it.
- R11: After reset every line is Invalid, and `bus_req` and `cpu_done` are low.
- R12: `bus_req`, `bus_cmd` and `bus_addr` hold steady until `bus_gnt`. `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compete_en | input | 1 | Enables the use counters and invalidate-on-zero |
| cpu_req | input | 1 | Processor request pulse, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transfer happens in that cycle |
| bus_cmd | output | 2 | 0 idle, 1 fill, 2 update, 3 writeback |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Update or writeback word |
| bus_rdata | input | DATA_W | Fill word from memory or an owning peer |
| bus_shared_in | input | 1 | Wired-OR from peers that hold the address |
| snp_rd | input | 1 | Peer read observed |
| snp_upd | input | 1 | Peer update observed |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped address |
| snp_supply | output | 1 | This cache owns the snooped line and supplies it |
| snp_sdata | output | DATA_W | Supplied word |

## Verification
The bench uses the default parameters: four lines, 8-bit addresses, 16-bit words and a 2-bit counter. Random traffic is drawn from sixteen addresses, so four tags compete for each line and dirty and clean evictions happen often. Because the counter is only two bits wide, at most four consecutive snooped updates reach the invalidate-on-zero case. Random switching of `compete_en` and of the peer-sharing input covers both the sole-holder shortcut and the update broadcast.

// File: rtl/wu_pkg.sv
package wu_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_E  = 3'd1,
    ST_SC = 3'd2,
    ST_SM = 3'd3,
    ST_M  = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  function automatic logic is_dirty(input line_st_t s);
    return (s == ST_SM) || (s == ST_M);
  endfunction

  function automatic line_st_t rd_demote(input line_st_t s);
    case (s)
      ST_E:    return ST_SC;
      ST_M:    return ST_SM;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/wu_line_store.sv
module wu_line_store
  import wu_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic [CNT_W-1:0]  a_cnt_o,
  input  logic              a_we,
  input  line_st_t          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic [CNT_W-1:0]  a_cnt,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic [CNT_W-1:0]  b_cnt_o,
  input  logic              b_we,
  input  line_st_t          b_st,
  input  logic [DATA_W-1:0] b_data,
  input  logic [CNT_W-1:0]  b_cnt
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [CNT_W-1:0]  cnt_q  [LINES];

  logic same_line;
  assign same_line = a_we && (a_idx == b_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (a_we && a_idx == IDX_W'(i)) begin
          st_q[i]   <= a_st;
          tag_q[i]  <= a_tag;
          data_q[i] <= a_data;
          cnt_q[i]  <= a_cnt;
        end else if (b_we && b_idx == IDX_W'(i)) begin
          st_q[i]   <= b_st;
          data_q[i] <= b_data;
          cnt_q[i]  <= b_cnt;
        end
      end
    end
  end

  assign a_st_o   = st_q[a_idx];
  assign a_tag_o  = tag_q[a_idx];
  assign a_data_o = data_q[a_idx];
  assign a_cnt_o  = cnt_q[a_idx];
  assign b_st_o   = st_q[b_idx];
  assign b_tag_o  = tag_q[b_idx];
  assign b_data_o = data_q[b_idx];
  assign b_cnt_o  = cnt_q[b_idx];

  // R10
  snoop_kill_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_we && b_st == ST_I && !same_line) |=> st_q[$past(b_idx)] == ST_I);

endmodule

// File: rtl/wu_snoop_unit.sv
module wu_snoop_unit
  import wu_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              snp_rd,
  input  logic              snp_upd,
  input  logic              compete_en,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [DATA_W-1:0] snp_data,
  input  line_st_t          b_st,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  input  logic [CNT_W-1:0]  b_cnt,
  output logic              hit,
  output logic              supply,
  output logic              kill,
  output logic              b_we,
  output line_st_t          b_st_nx,
  output logic [DATA_W-1:0] b_data_nx,
  output logic [CNT_W-1:0]  b_cnt_nx
);
  function automatic logic [CNT_W-1:0] cnt_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction

  assign hit    = (b_st != ST_I) && (b_tag == snp_tag);
  assign supply = snp_rd && hit && is_dirty(b_st);
  assign kill   = snp_upd && hit && compete_en && (b_cnt == '0);
  assign b_we   = hit && (snp_rd || snp_upd);

  always_comb begin
    b_st_nx   = b_st;
    b_data_nx = b_data;
    b_cnt_nx  = b_cnt;
    if (kill) begin
      b_st_nx = ST_I;
    end else if (snp_upd) begin
      b_st_nx   = ST_SC;
      b_data_nx = snp_data;
      if (compete_en) b_cnt_nx = cnt_down(b_cnt);
    end else if (snp_rd) begin
      b_st_nx = rd_demote(b_st);
    end
  end

endmodule

// File: rtl/wu_req_fsm.sv
module wu_req_fsm
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    compete_en,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    bus_shared_in,
  output logic                    fsm_idle,
  output logic [IDX_W-1:0]        a_idx,
  input  line_st_t                a_st_rd,
  input  logic [ADDR_W-IDX_W-1:0] a_tag_rd,
  input  logic [DATA_W-1:0]       a_data_rd,
  input  logic [CNT_W-1:0]        a_cnt_rd,
  output logic                    a_we,
  output line_st_t                a_st,
  output logic [ADDR_W-IDX_W-1:0] a_tag,
  output logic [DATA_W-1:0]       a_data,
  output logic [CNT_W-1:0]        a_cnt
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {P_IDLE, P_EVAL, P_BUS} phase_t;

  function automatic logic [CNT_W-1:0] cnt_up(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + CNT_W'(1);
  endfunction

  phase_t            ph_q, ph_nx;
  bus_cmd_t          cmd_q, cmd_nx;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fin;

  logic [TAG_W-1:0] req_tag;
  logic             hit;
  logic [CNT_W-1:0] used_cnt;
  // named events for the checks below
  logic ev_upd, ev_wb, ev_fill, ev_sole;

  assign req_tag  = addr_q[ADDR_W-1:IDX_W];
  assign a_idx    = addr_q[IDX_W-1:0];
  assign hit      = (a_st_rd != ST_I) && (a_tag_rd == req_tag);
  assign used_cnt = compete_en ? cnt_up(a_cnt_rd) : a_cnt_rd;

  always_comb begin
    ph_nx   = ph_q;
    cmd_nx  = cmd_q;
    a_we    = 1'b0;
    a_st    = a_st_rd;
    a_tag   = a_tag_rd;
    a_data  = a_data_rd;
    a_cnt   = a_cnt_rd;
    fin     = 1'b0;
    ev_upd  = 1'b0;
    ev_wb   = 1'b0;
    ev_fill = 1'b0;
    ev_sole = 1'b0;
    case (ph_q)
      P_IDLE: if (cpu_req) ph_nx = P_EVAL;
      P_EVAL: begin
        if (hit) begin
          if (!we_q) begin
            a_we = 1'b1; a_cnt = used_cnt; fin = 1'b1; ph_nx = P_IDLE;
          end else if (a_st_rd == ST_E || a_st_rd == ST_M || !bus_shared_in) begin
            ev_sole = (a_st_rd == ST_SC || a_st_rd == ST_SM);
            a_we = 1'b1; a_st = ST_M; a_data = wd_q; a_cnt = used_cnt;
            fin = 1'b1; ph_nx = P_IDLE;
          end else begin
            ph_nx = P_BUS; cmd_nx = BC_UPD;
          end
        end else if (is_dirty(a_st_rd)) begin
          ph_nx = P_BUS; cmd_nx = BC_WB;
        end else begin
          ph_nx = P_BUS; cmd_nx = BC_READ;
        end
      end
      P_BUS: if (bus_gnt) begin
        case (cmd_q)
          BC_UPD: begin
            ev_upd = 1'b1;
            a_we = 1'b1; a_data = wd_q; a_cnt = used_cnt;
            a_st = bus_shared_in ? ST_SM : ST_M;
            fin = 1'b1; ph_nx = P_IDLE;
          end
          BC_WB: begin
            ev_wb = 1'b1;
            a_we = 1'b1; a_st = ST_I; cmd_nx = BC_READ;
          end
          default: begin
            ev_fill = 1'b1;
            a_we = 1'b1; a_tag = req_tag; a_data = bus_rdata;
            a_st = bus_shared_in ? ST_SC : ST_E;
            a_cnt = {CNT_W{1'b1}};
            ph_nx = P_EVAL;
          end
        endcase
      end
      default: ph_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= P_IDLE;
      cmd_q   <= BC_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      ph_q   <= ph_nx;
      cmd_q  <= cmd_nx;
      done_q <= fin;
      if (ph_q == P_IDLE && cpu_req) begin
        we_q   <= cpu_we;
        addr_q <= cpu_addr;
        wd_q   <= cpu_wdata;
      end
      if (fin) rdata_q <= we_q ? wd_q : a_data_rd;
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign fsm_idle  = (ph_q == P_IDLE);
  assign bus_req   = (ph_q == P_BUS);
  assign bus_cmd   = (ph_q == P_BUS) ? cmd_q : BC_NONE;
  assign bus_addr  = (cmd_q == BC_WB) ? {a_tag_rd, a_idx} : addr_q;
  assign bus_wdata = (cmd_q == BC_WB) ? a_data_rd : wd_q;

  // R2
  upd_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd |-> (a_st_rd == ST_SC || a_st_rd == ST_SM));
  // R3
  sole_holder_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sole |=> !bus_req);
  // R5
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |-> is_dirty(a_st_rd));
  // R1
  fill_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> !hit);
  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

// File: rtl/wu_coh_ctrl.sv
module wu_coh_ctrl
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              compete_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_rd,
  input  logic              snp_upd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_sdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  line_st_t          a_st_rd, a_st_wr;
  logic [TAG_W-1:0]  a_tag_rd, a_tag_wr;
  logic [DATA_W-1:0] a_data_rd, a_data_wr;
  logic [CNT_W-1:0]  a_cnt_rd, a_cnt_wr;
  logic              a_we;

  line_st_t          b_st_rd, b_st_wr;
  logic [TAG_W-1:0]  b_tag_rd;
  logic [DATA_W-1:0] b_data_rd, b_data_wr;
  logic [CNT_W-1:0]  b_cnt_rd, b_cnt_wr;
  logic              b_we;
  logic              snp_hit, snp_kill;
  logic              fsm_idle;

  wu_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st_o(a_st_rd), .a_tag_o(a_tag_rd), .a_data_o(a_data_rd), .a_cnt_o(a_cnt_rd),
    .a_we(a_we), .a_st(a_st_wr), .a_tag(a_tag_wr), .a_data(a_data_wr), .a_cnt(a_cnt_wr),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st_o(b_st_rd), .b_tag_o(b_tag_rd), .b_data_o(b_data_rd),
    .b_cnt_o(b_cnt_rd),
    .b_we(b_we), .b_st(b_st_wr), .b_data(b_data_wr), .b_cnt(b_cnt_wr)
  );

  wu_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_snoop (
    .snp_rd(snp_rd), .snp_upd(snp_upd), .compete_en(compete_en),
    .snp_tag(snp_addr[ADDR_W-1:IDX_W]), .snp_data(snp_data),
    .b_st(b_st_rd), .b_tag(b_tag_rd), .b_data(b_data_rd), .b_cnt(b_cnt_rd),
    .hit(snp_hit), .supply(snp_supply), .kill(snp_kill), .b_we(b_we),
    .b_st_nx(b_st_wr), .b_data_nx(b_data_wr), .b_cnt_nx(b_cnt_wr)
  );

  wu_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .compete_en(compete_en),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .fsm_idle(fsm_idle),
    .a_idx(a_idx), .a_st_rd(a_st_rd), .a_tag_rd(a_tag_rd), .a_data_rd(a_data_rd),
    .a_cnt_rd(a_cnt_rd), .a_we(a_we), .a_st(a_st_wr), .a_tag(a_tag_wr),
    .a_data(a_data_wr), .a_cnt(a_cnt_wr)
  );

  assign snp_shared = snp_hit;
  assign snp_sdata  = b_data_rd;

  // R6
  snoop_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_rd || snp_upd) && fsm_idle && !cpu_req) |=> !bus_req);
  // R10
  kill_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |-> (snp_shared && !snp_supply));

endmodule

// File: tb/sim_wu_coh_ctrl.sv
module sim_wu_coh_ctrl;
  localparam int CLK_P = 10;
  localparam int MI = 0, ME = 1, MSC = 2, MSM = 3, MM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        compete_en = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_shared_in = 1'b0;
  logic        snp_rd = 1'b0, snp_upd = 1'b0;
  logic [7:0]  snp_addr = '0;
  logic [15:0] snp_data = '0;
  logic        snp_shared, snp_supply;
  logic [15:0] snp_sdata;

  logic [15:0] mem [256];
  int          m_st [4];
  logic [5:0]  m_tag [4];
  logic [15:0] m_data [4];
  int          m_cnt [4];
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  wu_coh_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .compete_en(compete_en),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_rd(snp_rd), .snp_upd(snp_upd), .snp_addr(snp_addr), .snp_data(snp_data),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_sdata(snp_sdata)
  );

  function automatic int f_up(input int c);
    return (c >= 3) ? 3 : c + 1;
  endfunction
  function automatic int f_dn(input int c);
    return (c <= 0) ? 0 : c - 1;
  endfunction

  task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                        input bit peers, input bit cen);
    int idx, st, cnt, en, seen, cyc;
    logic [5:0] tg;
    logic [15:0] dat;
    bit hit, fin;
    int ec [3];
    logic [7:0] ea [3];
    logic [15:0] ed [3];
    string rq [3];
    string quiet;
    idx = int'(addr[1:0]);
    tg  = addr[7:2];
    hit = (m_st[idx] != MI) && (m_tag[idx] == tg);
    en = 0;
    quiet = "R1";
    if (!hit && (m_st[idx] == MSM || m_st[idx] == MM)) begin
      ec[en] = 3; ea[en] = {m_tag[idx], addr[1:0]}; ed[en] = m_data[idx]; rq[en] = "R5"; en++;
    end
    if (!hit) begin
      ec[en] = 1; ea[en] = addr; ed[en] = 'x; rq[en] = "R1"; en++;
      st = peers ? MSC : ME; cnt = 3; dat = mem[addr];
      if (en == 2) dat = (ea[0] == addr) ? ed[0] : mem[addr];
    end else begin
      st = m_st[idx]; cnt = m_cnt[idx]; dat = m_data[idx];
    end
    if (we) begin
      if (st == ME || st == MM) begin st = MM; quiet = "R4"; end
      else if (!peers) begin st = MM; quiet = "R3"; end
      else begin ec[en] = 2; ea[en] = addr; ed[en] = wd; rq[en] = "R2"; en++; st = MSM; end
      dat = wd;
    end
    if (cen) cnt = f_up(cnt);

    @(negedge clk);
    bus_shared_in = peers; compete_en = cen;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    seen = 0; fin = 0; cyc = 0;
    while (!fin && cyc < 60) begin
      if (cpu_done) fin = 1;
      else if (bus_req) begin
        if (seen < en) begin
          check(rq[seen], 32'(bus_cmd), 32'(ec[seen]));
          check(rq[seen], 32'(bus_addr), 32'(ea[seen]));
          if (ec[seen] != 1) check(rq[seen], 32'(bus_wdata), 32'(ed[seen]));
        end else begin
          check({quiet, " unexpected bus request"}, 32'(bus_cmd), 32'd0);
        end
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        seen++;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        cyc++;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check("R12 access completes", 32'(fin), 32'd1);
    check({quiet, " transaction count"}, 32'(seen), 32'(en));
    if (!we) check("R1 read data", 32'(cpu_rdata), 32'(dat));
    @(negedge clk);
    check("R12 done pulse", 32'(cpu_done), 32'd0);
    bus_shared_in = 1'b0;
    m_st[idx] = st; m_tag[idx] = tg; m_data[idx] = dat; m_cnt[idx] = cnt;
  endtask

  task automatic snoop(input bit upd, input logic [7:0] addr, input logic [15:0] d, input bit cen);
    int idx;
    bit hit, dirty;
    idx = int'(addr[1:0]);
    hit = (m_st[idx] != MI) && (m_tag[idx] == addr[7:2]);
    dirty = (m_st[idx] == MSM || m_st[idx] == MM);
    @(negedge clk);
    compete_en = cen; snp_rd = !upd; snp_upd = upd; snp_addr = addr; snp_data = d;
    #1;
    check("R7 shared line", 32'(snp_shared), 32'(hit));
    check("R6 supply", 32'(snp_supply), 32'(!upd && hit && dirty));
    if (!upd && hit && dirty) check("R6 supplied word", 32'(snp_sdata), 32'(m_data[idx]));
    @(negedge clk);
    snp_rd = 1'b0; snp_upd = 1'b0;
    check("R6 no bus from snoop", 32'(bus_req), 32'd0);
    if (hit) begin
      if (upd) begin
        if (cen && m_cnt[idx] == 0) m_st[idx] = MI;
        else begin
          m_st[idx] = MSC; m_data[idx] = d;
          if (cen) m_cnt[idx] = f_dn(m_cnt[idx]);
        end
      end else begin
        if (m_st[idx] == ME) m_st[idx] = MSC;
        else if (m_st[idx] == MM) m_st[idx] = MSM;
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL R12 watchdog got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
    for (int i = 0; i < 4; i++) begin m_st[i] = MI; m_tag[i] = '0; m_data[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 bus_req", 32'(bus_req), 32'd0);
    check("R11 cpu_done", 32'(cpu_done), 32'd0);
    snp_addr = 8'h00; #1 check("R11 line invalid", 32'(snp_shared), 32'd0);

    // R1 miss fills Exclusive, R4 silent write
    access(0, 8'h10, 16'h0, 0, 1);
    access(1, 8'h10, 16'hA1A1, 1, 1);
    // R6 snoop read of Modified supplies, demotes to SharedModified
    snoop(0, 8'h10, 16'h0, 1);
    // R2 update broadcast from SharedModified
    access(1, 8'h10, 16'hB2B2, 1, 1);
    // R3 sole holder goes Modified silently
    access(1, 8'h10, 16'hC3C3, 0, 1);
    // R5 dirty eviction then fill
    access(0, 8'h20, 16'h0, 1, 1);
    // R5 clean eviction is silent
    access(0, 8'h30, 16'h0, 0, 1);
    // R8, R9, R10 counter drains over updates then invalidates
    access(0, 8'h05, 16'h0, 1, 1);
    for (int k = 0; k < 4; k++) snoop(1, 8'h05, 16'h5000 + 16'(k), 1);
    access(0, 8'h05, 16'h0, 1, 1);
    // R9 counter frozen when mode is off: updates never invalidate
    for (int k = 0; k < 6; k++) snoop(1, 8'h05, 16'h6000 + 16'(k), 0);
    access(0, 8'h05, 16'h0, 1, 0);
    // R7 miss on different tag
    snoop(0, 8'h09, 16'h0, 0);

    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int r;
      a = 8'($urandom % 16);
      r = int'($urandom % 10);
      if (r < 6) access(bit'($urandom % 2), a, 16'($urandom), bit'($urandom % 2),
                        ($urandom % 4) != 0);
      else snoop(bit'(r < 9), a, 16'($urandom), ($urandom % 4) != 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule